// File: doc/BRIEF.md
# Eight-bit Timer with Compare Channels and PWM

This block is a bus-programmed 8-bit counter that advances once for every cycle on which its count-enable input is high. That input is fed by a prescaler or an edge detector outside the block. Two compare channels, A and B, each watch the count and drive one waveform output. Three counting schemes are available. The first is a free-running up-count that wraps from 0xFF to 0x00. The second is an up-count that restarts from zero after matching compare value A, which sets the period. The third is a dual-slope phase-correct PWM whose turning point is either 0xFF or compare value A.

Software writes the control, count, compare, flag and mask registers through a simple synchronous write port, and reads them back combinationally. Three event flags (overflow, match A, match B) are merged through the mask into one interrupt request. In the dual-slope modes the compare values are double-buffered, so a new duty cycle never produces a short or split pulse. A stop bit in the control register freezes the counter, the flags and the outputs.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset the count, the compare buffers, the flags and the mask read 0, and wave_a, wave_b and irq are low. Register addresses: 0 control, 1 count, 2 compare A, 3 compare B, 4 flags, 5 mask.
- R2: With control mode bits [1:0]=0, each enabled tick adds one to the count. The step from 0xFF to 0x00 sets flag bit 0 (overflow).
- R3: When cnt_en is low, or when control bit 7 (stop) is set, the count does not change and no flag is set.
- R4: With mode 1, a tick taken while the count equals compare A loads zero into the count and sets flag bit 1 (match A).
- R5: In modes 0 and 1, control bit 2 makes wave_a invert on each match of channel A, and control bit 3 does the same for wave_b on channel B.
- R6: Modes 2 (turning point 0xFF) and 3 (turning point compare A) count up to the turning point and then down to 0, one step per tick. A tick taken at 0 sets flag bit 0.
- R7: In modes 2 and 3, a channel match taken while counting up drives its wave output low, and a match taken while counting down drives it high.
- R8: In modes 2 and 3, a compare write changes only the buffer that is read back at addresses 2 and 3. The value in use is updated at the tick taken at the turning point. In modes 0 and 1 the write applies at once.
- R9: Writing 1 to a bit of the flag register (address 4) clears that flag, and writing 0 leaves it unchanged. Flag bit 2 is match B.
- R10: irq is high exactly when some flag bit is set whose mask bit (address 5, same positions) is also set.
- R11: A write to the count register (address 1) loads the count and suppresses any compare match on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count enable pulse from prescaler or edge detector |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| wave_a | output | 1 | Waveform output of channel A |
| wave_b | output | 1 | Waveform output of channel B |
| irq | output | 1 | Masked OR of the event flags |

## Verification
On every cycle the assertions check the following: the count holds when there is no tick, the dual-slope count moves by at most one step, the restart-on-match returns to zero, each match drives the output level that the current direction and mode call for, the active compare values stay fixed between turning points, and write-one-to-clear works. Some behaviour can only be shown by the bench's scenarios, because it depends on sequences of register writes and tick counts. This covers the time at which the double buffer takes a new value, as seen through the match-B flag, the suppression of a match after a count write, the stop bit, the interrupt masking and the full up-and-down trajectory in both dual-slope variants.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR     = 2'd1,
    MODE_PC_MAX  = 2'd2,
    MODE_PC_CMPA = 2'd3
  } tmode_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CMPA = 3'd2;
  localparam logic [2:0] A_CMPB = 3'd3;
  localparam logic [2:0] A_FLAG = 3'd4;
  localparam logic [2:0] A_MASK = 3'd5;

  localparam int NCH   = 2;
  localparam int NFLAG = NCH + 1;

  localparam int C_TOG_A = 2;
  localparam int C_STOP  = 7;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  tmode_e       mode,
  input  logic [W-1:0] top,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         blk,
  output logic         ev_ovf,
  output logic         reload
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BOT  = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d, blk_q, blk_d;
  logic         pc;

  assign pc = mode[1];

  always_comb begin
    cnt_d  = cnt_q;
    up_d   = up_q;
    blk_d  = blk_q;
    ev_ovf = 1'b0;
    reload = 1'b0;
    if (tick) begin
      blk_d = 1'b0;
      if (pc) begin
        if (cnt_q == BOT) ev_ovf = 1'b1;
        if (up_q) begin
          if (cnt_q >= top) begin
            up_d   = 1'b0;
            reload = 1'b1;
            cnt_d  = (cnt_q == BOT) ? BOT : cnt_q - 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (cnt_q == BOT) begin
          up_d  = 1'b1;
          cnt_d = (top == BOT) ? BOT : cnt_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        if (cnt_q == MAXV) ev_ovf = 1'b1;
        if (mode == MODE_CLR && cnt_q == top) cnt_d = BOT;
        else                                  cnt_d = cnt_q + 1'b1;
      end
    end
    if (!pc) up_d = 1'b1;
    if (load) begin
      cnt_d = load_val;
      blk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      blk_q <= blk_d;
    end
  end

  assign cnt = cnt_q;
  assign up  = up_q;
  assign blk = blk_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pc && !load) |=>
      (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1 || cnt_q == $past(cnt_q)));

  assert_clr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_CLR && cnt_q == top && !load) |=> (cnt_q == BOT));
endmodule

// File: rtl/tmr8_cmp_unit.sv
module tmr8_cmp_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] ocr,
  input  logic         blk,
  input  logic         up,
  input  logic         pc,
  input  logic         tog,
  output logic         match,
  output logic         wave
);
  logic wave_q, wave_d;

  assign match = tick && !blk && (cnt == ocr);

  always_comb begin
    wave_d = wave_q;
    if (match) begin
      if (pc)       wave_d = !up;
      else if (tog) wave_d = !wave_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  assert_pc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && pc && up) |=> !wave_q);

  assert_pc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && pc && !up) |=> wave_q);

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !pc && tog) |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [2:0]            addr,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rdata,
  input  logic [W-1:0]          cnt_val,
  input  logic                  ev_ovf,
  input  logic [NCH-1:0]        ev_match,
  input  logic                  reload,
  output tmode_e                mode,
  output logic [NCH-1:0]        tog,
  output logic                  stop,
  output logic                  cnt_load,
  output logic [NCH-1:0][W-1:0] ocr_act,
  output logic                  irq
);
  logic [W-1:0]          ctrl_q, ctrl_d;
  logic [NCH-1:0][W-1:0] buf_q, buf_d, act_q, act_d;
  logic [NFLAG-1:0]      flag_q, flag_d, mask_q, mask_d, ev;
  logic                  pc;

  assign ev   = {ev_match, ev_ovf};
  assign mode = tmode_e'(ctrl_q[1:0]);
  assign pc   = ctrl_q[1];
  assign stop = ctrl_q[C_STOP];
  assign tog  = ctrl_q[C_TOG_A +: NCH];

  always_comb begin
    ctrl_d = ctrl_q;
    buf_d  = buf_q;
    mask_d = mask_q;
    flag_d = flag_q | ev;
    if (we) begin
      case (addr)
        A_CTRL:  ctrl_d   = wdata;
        A_CMPA:  buf_d[0] = wdata;
        A_CMPB:  buf_d[1] = wdata;
        A_FLAG:  flag_d   = (flag_q & ~wdata[NFLAG-1:0]) | ev;
        A_MASK:  mask_d   = wdata[NFLAG-1:0];
        default: ;
      endcase
    end
    act_d = act_q;
    if (!pc || reload) act_d = buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      buf_q  <= buf_d;
      act_q  <= act_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_CNT:   rdata = cnt_val;
      A_CMPA:  rdata = buf_q[0];
      A_CMPB:  rdata = buf_q[1];
      A_FLAG:  rdata = {{(W-NFLAG){1'b0}}, flag_q};
      A_MASK:  rdata = {{(W-NFLAG){1'b0}}, mask_q};
      default: rdata = '0;
    endcase
  end

  assign cnt_load = we && (addr == A_CNT);
  assign ocr_act  = act_q;
  assign irq      = |(flag_q & mask_q);

  assert_dbuf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc && !reload) |=> $stable(act_q));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_FLAG && ev == '0) |=> ((flag_q & $past(wdata[NFLAG-1:0])) == '0));
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         bus_we,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         wave_a,
  output logic         wave_b,
  output logic         irq
);
  logic [1:0]            rst_sync;
  logic                  rst_n_s;
  logic                  tick, stop, cnt_load, up, blk, ev_ovf, reload;
  tmode_e                mode;
  logic [NCH-1:0]        tog, match, wave;
  logic [NCH-1:0][W-1:0] ocr_act;
  logic [W-1:0]          cnt, top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  assign tick = cnt_en && !stop;
  assign top  = (mode == MODE_CLR || mode == MODE_PC_CMPA) ? ocr_act[0] : '1;

  tmr8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .cnt_val(cnt), .ev_ovf(ev_ovf), .ev_match(match),
    .reload(reload), .mode(mode), .tog(tog), .stop(stop), .cnt_load(cnt_load),
    .ocr_act(ocr_act), .irq(irq)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .mode(mode), .top(top),
    .load(cnt_load), .load_val(bus_wdata), .cnt(cnt), .up(up), .blk(blk),
    .ev_ovf(ev_ovf), .reload(reload)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr8_cmp_unit #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_n_s), .tick(tick), .cnt(cnt), .ocr(ocr_act[i]),
      .blk(blk), .up(up), .pc(mode[1]), .tog(tog[i]),
      .match(match[i]), .wave(wave[i])
    );
  end

  assign wave_a = wave[0];
  assign wave_b = wave[1];

  assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tick) |-> (match == '0 && !ev_ovf));
endmodule

// File: tb/sim_tmr8_pwm.sv
module sim_tmr8_pwm;
  logic       clk = 1'b0;
  logic       rst_n, cnt_en, bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       wave_a, wave_b, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  tmr8_pwm u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
  );

  // {kind, addr, data, expect, req}; kind 0 write, 1 tick n, 2 read, 3 outputs {irq,wave_b,wave_a}
  localparam int NV = 50;
  localparam logic [24:0] VEC [NV] = '{
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd1},   // R1 count
    {2'd2, 3'd4, 8'h00, 8'h00, 4'd1},   // R1 flags
    {2'd3, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 outputs
    {2'd0, 3'd2, 8'h80, 8'h00, 4'd0},
    {2'd0, 3'd3, 8'h90, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd5,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h05, 4'd2},   // R2 up count
    {2'd0, 3'd1, 8'hFE, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd2,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd2},   // R2 wrap
    {2'd2, 3'd4, 8'h00, 8'h01, 4'd2},   // R2 overflow flag
    {2'd0, 3'd4, 8'h01, 8'h00, 4'd0},
    {2'd2, 3'd4, 8'h00, 8'h00, 4'd9},   // R9 write-one clear
    {2'd0, 3'd0, 8'h80, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd3,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd3},   // R3 stopped count
    {2'd2, 3'd4, 8'h00, 8'h00, 4'd3},   // R3 no flags
    {2'd0, 3'd0, 8'h05, 8'h00, 4'd0},
    {2'd0, 3'd1, 8'h80, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd1,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd4},   // R4 restart at compare A
    {2'd2, 3'd4, 8'h00, 8'h00, 4'd11},  // R11 match suppressed after count write
    {2'd0, 3'd2, 8'h03, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd4,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h00, 4'd4},   // R4 period 4
    {2'd2, 3'd4, 8'h00, 8'h02, 4'd4},   // R4 match A flag
    {2'd3, 3'd0, 8'h00, 8'h01, 4'd5},   // R5 toggled high
    {2'd1, 3'd0, 8'd4,  8'h00, 4'd0},
    {2'd3, 3'd0, 8'h00, 8'h00, 4'd5},   // R5 toggled low
    {2'd0, 3'd5, 8'h02, 8'h00, 4'd0},
    {2'd3, 3'd0, 8'h00, 8'h04, 4'd10},  // R10 irq raised
    {2'd0, 3'd4, 8'h02, 8'h00, 4'd0},
    {2'd3, 3'd0, 8'h00, 8'h00, 4'd10},  // R10 irq dropped
    {2'd0, 3'd5, 8'h00, 8'h00, 4'd0},
    {2'd0, 3'd0, 8'h03, 8'h00, 4'd0},
    {2'd0, 3'd3, 8'h02, 8'h00, 4'd0},
    {2'd2, 3'd3, 8'h00, 8'h02, 4'd8},   // R8 buffer readback
    {2'd1, 3'd0, 8'd4,  8'h00, 4'd0},
    {2'd2, 3'd4, 8'h00, 8'h03, 4'd8},   // R8 no early match B
    {2'd2, 3'd1, 8'h00, 8'h02, 4'd6},   // R6 turned at compare A
    {2'd1, 3'd0, 8'd1,  8'h00, 4'd0},
    {2'd3, 3'd0, 8'h00, 8'h02, 4'd7},   // R7 set on down match
    {2'd1, 3'd0, 8'd2,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'h01, 4'd6},   // R6 turned at bottom
    {2'd1, 3'd0, 8'd2,  8'h00, 4'd0},
    {2'd3, 3'd0, 8'h00, 8'h00, 4'd7},   // R7 clear on up match
    {2'd0, 3'd0, 8'h02, 8'h00, 4'd0},
    {2'd0, 3'd1, 8'hFE, 8'h00, 4'd0},
    {2'd1, 3'd0, 8'd2,  8'h00, 4'd0},
    {2'd2, 3'd1, 8'h00, 8'hFE, 4'd6}    // R6 turned at 0xFF
  };

  task automatic check(input int req, input int idx, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d step %0d: got %h expected %h", req, idx, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [7:0] dat, exp;
      kind = VEC[i][24:23];
      dat  = VEC[i][19:12];
      exp  = VEC[i][11:4];
      bus_addr = VEC[i][22:20];
      case (kind)
        2'd0: begin
          bus_wdata = dat; bus_we = 1'b1;
          @(negedge clk);
          bus_we = 1'b0;
        end
        2'd1: begin
          cnt_en = 1'b1;
          repeat (int'(dat)) @(negedge clk);
          cnt_en = 1'b0;
        end
        2'd2: begin
          #1;
          check(int'(VEC[i][3:0]), i, bus_rdata, exp);
        end
        default: begin
          #1;
          check(int'(VEC[i][3:0]), i, {5'b0, irq, wave_b, wave_a}, exp);
        end
      endcase
      if (kind >= 2'd2) @(negedge clk);
    end

    // Directed: reset in the middle of dual-slope operation with flags and mask set (R1)
    bus_addr = 3'd5; bus_wdata = 8'h07; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    cnt_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_en = 1'b0;
    rst_n = 1'b0;
    #1;
    bus_addr = 3'd1; #1;
    check(1, 100, bus_rdata, 8'h00);
    bus_addr = 3'd4; #1;
    check(1, 101, bus_rdata, 8'h00);
    check(1, 102, {5'b0, irq, wave_b, wave_a}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_addr = 3'd2; #1;
    check(1, 103, bus_rdata, 8'h00);
    bus_addr = 3'd5; #1;
    check(1, 104, bus_rdata, 8'h00);
    // Directed: enable low leaves count unchanged (R3)
    repeat (5) @(negedge clk);
    bus_addr = 3'd1; #1;
    check(3, 105, bus_rdata, 8'h00);
    finish_run();
  end
endmodule